// File: doc/BRIEF.md
# Interrupt Controller Byte Register Interface

This block is the host-facing register port of a small interrupt controller with up to eight request lines. A host writes and reads bytes at two addresses. The block sorts each write into an initialisation word, a mode command or an end-of-service/priority command. It holds the configuration that results: the vector base, the auto-acknowledge and nested-mode options, the special mask flag and the line mask. It answers reads from the pending, in-service and mask registers.

Initialisation follows a short sequence. A start word on address 0 clears the configuration. The next address-1 write gives the vector base. A third address-1 write is consumed without effect. A fourth address-1 write, which carries the mode options, is expected only when the start word asked for it. After that, address-1 writes load the line mask.

A mode command can arm a one-shot poll. The next read then returns the line chosen by the priority core and pulses an acknowledge so that the core clears that line's pending and in-service bits. End-of-service and priority commands are not acted on here: they leave the block as a one-cycle strobe carrying a 3-bit code and a line number. The priority core also supplies the winning line, and the block forms the acknowledge vector from it.

Top module: `pic_regif`

## Requirements
- R1: A write to address 0 with data bit 4 set pulses `init_clr` in that cycle. From the next cycle, mask, vector base, auto-acknowledge, nested mode, special mask, read-select and poll are all 0. The sequencer then waits for the vector base, and data bit 0 is kept as the "mode word follows" flag.
- R2: The first address-1 write after the start word sets `vec_base` to the data with its low log2(LINES) bits forced to 0, which is data AND 0xF8 for eight lines.
- R3: The second address-1 write after the start word changes no output. The sequencer then expects the mode word if the flag from R1 is 1, and otherwise returns to normal operation.
- R4: The mode word sets `sfn_mode` from data bit 4 and `auto_eoi` from data bit 1, then returns the sequencer to normal operation.
- R5: In normal operation an address-1 write loads `imr` from the low LINES data bits. Address-1 writes made during the initialisation sequence leave `imr` unchanged.
- R6: An address-0 write with bit 4 clear and bit 3 set is a mode command. Bit 2 set arms poll. Bit 1 set loads read-select from bit 0. Bit 6 set loads `spec_mask` from bit 5. Any field whose enable bit is clear keeps its value. No command strobe is raised.
- R7: An address-0 write with bits 4 and 3 both clear raises `cmd_valid` for that cycle, with `cmd_code` taken from data bits 7:5 and `cmd_level` from data bits 2:0. No other write raises it.
- R8: A read made while poll is armed returns `win_line` if `win_valid` is 1, and in that case also pulses `poll_ack` with `poll_line` equal to `win_line`. If `win_valid` is 0 the read returns LINES-1 and does not pulse `poll_ack`. Either way the read disarms poll.
- R9: With poll disarmed, an address-0 read returns `insvc` when read-select is 1 and `pend` when it is 0. An address-1 read returns `imr`.
- R10: `ack_vector` equals `vec_base` OR the line number, where the line number is `win_line` when `win_valid` is 1 and LINES-1 when it is 0.
- R11: After reset, `imr`, `vec_base`, `auto_eoi`, `sfn_mode` and `spec_mask` are 0, no strobe is active, and address-0 reads return `pend`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 1 | Register address select |
| wr | input | 1 | Write strobe, one cycle per byte |
| rd | input | 1 | Read strobe, one cycle per byte |
| wdata | input | DATA_W | Write data |
| pend | input | LINES | Pending register from the priority core |
| insvc | input | LINES | In-service register from the priority core |
| win_valid | input | 1 | Priority core has a winning line |
| win_line | input | LINE_W | Winning line number |
| rdata | output | DATA_W | Read data, valid while `rd` is high |
| vec_base | output | DATA_W | Vector base with low bits cleared |
| auto_eoi | output | 1 | Auto-acknowledge option |
| sfn_mode | output | 1 | Special fully nested option |
| spec_mask | output | 1 | Special mask flag |
| imr | output | LINES | Line mask register |
| init_clr | output | 1 | Start-word pulse; clears core state and drops the request output |
| cmd_valid | output | 1 | End-of-service/priority command strobe |
| cmd_code | output | 3 | Command code |
| cmd_level | output | LINE_W | Command line number |
| poll_ack | output | 1 | Poll read acknowledged a line |
| poll_line | output | LINE_W | Line acknowledged by a poll read |
| ack_vector | output | DATA_W | Vector number for the current winner |

## Verification
The assertions take for granted that `wr` and `rd` are never high in the same cycle, and that each strobe lasts exactly one cycle per byte. The poll-disarm and mask-hold properties rely on this. The stimulus issues every access as a single-cycle pulse from a task, with the strobe dropped before the next access begins. The winner inputs are held steady across each read, so the read value and the acknowledge are compared against one stable choice.

// File: rtl/pic_regif_pkg.sv
package pic_regif_pkg;
   typedef enum logic [1:0] {
      SEQ_RUN  = 2'd0,
      SEQ_BASE = 2'd1,
      SEQ_SKIP = 2'd2,
      SEQ_MODE = 2'd3
   } seq_st_e;

   // address-0 decode bits
   localparam int B_START   = 4;
   localparam int B_MODECMD = 3;
   localparam int B_POLL    = 2;
   localparam int B_RSEL_EN = 1;
   localparam int B_RSEL    = 0;
   localparam int B_SM_EN   = 6;
   localparam int B_SM      = 5;
   // start word and mode word bits
   localparam int B_NEED4   = 0;
   localparam int B_SFN     = 4;
   localparam int B_AEOI    = 1;
   // command code field
   localparam int CODE_LO   = 5;
   localparam int CODE_W    = 3;
endpackage

// File: rtl/pic_init_seq.sv
module pic_init_seq
   import pic_regif_pkg::*;
#(
   parameter int LINES  = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_w,
   input  logic              wr_hi,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] vec_base,
   output logic              auto_eoi,
   output logic              sfn_mode,
   output logic [LINES-1:0]  imr
);
   localparam logic [DATA_W-1:0] BASE_MASK = ~DATA_W'(LINES - 1);

   seq_st_e st;
   logic    need4;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= SEQ_RUN;
         need4    <= 1'b0;
         vec_base <= '0;
         auto_eoi <= 1'b0;
         sfn_mode <= 1'b0;
         imr      <= '0;
      end else if (start_w) begin
         st       <= SEQ_BASE;
         need4    <= wdata[B_NEED4];
         vec_base <= '0;
         auto_eoi <= 1'b0;
         sfn_mode <= 1'b0;
         imr      <= '0;
      end else if (wr_hi) begin
         unique case (st)
            SEQ_RUN:  imr <= wdata[LINES-1:0];
            SEQ_BASE: begin
               vec_base <= wdata & BASE_MASK;
               st       <= SEQ_SKIP;
            end
            SEQ_SKIP: st <= need4 ? SEQ_MODE : SEQ_RUN;
            SEQ_MODE: begin
               sfn_mode <= wdata[B_SFN];
               auto_eoi <= wdata[B_AEOI];
               st       <= SEQ_RUN;
            end
            default:  st <= SEQ_RUN;
         endcase
      end
   end

   AST_START_ENTERS_BASE: assert property (@(posedge clk) disable iff (!rst_n)
      start_w |=> (st == SEQ_BASE)); // R1
   AST_BASE_THEN_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
      (st == SEQ_BASE && wr_hi && !start_w) |=> (st == SEQ_SKIP)); // R2
   AST_SKIP_NO_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      (st == SEQ_SKIP && wr_hi && !start_w && !need4) |=> (st == SEQ_RUN)); // R3
   AST_MASK_HELD_IN_INIT: assert property (@(posedge clk) disable iff (!rst_n)
      (st != SEQ_RUN && wr_hi && !start_w) |=> $stable(imr)); // R5
endmodule

// File: rtl/pic_ocw_dec.sv
module pic_ocw_dec
   import pic_regif_pkg::*;
#(
   parameter int LINES  = 8,
   parameter int DATA_W = 8,
   localparam int LINE_W = $clog2(LINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              addr,
   input  logic              wr,
   input  logic              rd,
   input  logic [DATA_W-1:0] wdata,
   output logic              start_w,
   output logic              cmd_valid,
   output logic [CODE_W-1:0] cmd_code,
   output logic [LINE_W-1:0] cmd_level,
   output logic              poll_armed,
   output logic              rsel,
   output logic              spec_mask
);
   logic lo_w, mode_w;

   assign lo_w      = wr && !addr;
   assign start_w   = lo_w && wdata[B_START];
   assign mode_w    = lo_w && !wdata[B_START] && wdata[B_MODECMD];
   assign cmd_valid = lo_w && !wdata[B_START] && !wdata[B_MODECMD];
   assign cmd_code  = wdata[CODE_LO +: CODE_W];
   assign cmd_level = wdata[LINE_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         poll_armed <= 1'b0;
         rsel       <= 1'b0;
         spec_mask  <= 1'b0;
      end else begin
         if (rd) poll_armed <= 1'b0;
         if (start_w) begin
            poll_armed <= 1'b0;
            rsel       <= 1'b0;
            spec_mask  <= 1'b0;
         end else if (mode_w) begin
            if (wdata[B_POLL])    poll_armed <= 1'b1;
            if (wdata[B_RSEL_EN]) rsel       <= wdata[B_RSEL];
            if (wdata[B_SM_EN])   spec_mask  <= wdata[B_SM];
         end
      end
   end

   AST_POLL_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_w && wdata[B_POLL]) |=> poll_armed); // R6
   AST_SMASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_w && !(mode_w && wdata[B_SM_EN])) |=> $stable(spec_mask)); // R6
   AST_POLL_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && !wr) |=> !poll_armed); // R8
endmodule

// File: rtl/pic_rd_path.sv
module pic_rd_path #(
   parameter int LINES  = 8,
   parameter int DATA_W = 8,
   localparam int LINE_W = $clog2(LINES)
) (
   input  logic              addr,
   input  logic              rd,
   input  logic              poll_armed,
   input  logic              rsel,
   input  logic [LINES-1:0]  pend,
   input  logic [LINES-1:0]  insvc,
   input  logic [LINES-1:0]  imr,
   input  logic              win_valid,
   input  logic [LINE_W-1:0] win_line,
   input  logic [DATA_W-1:0] vec_base,
   output logic [DATA_W-1:0] rdata,
   output logic              poll_ack,
   output logic [LINE_W-1:0] poll_line,
   output logic [DATA_W-1:0] ack_vector
);
   localparam logic [LINE_W-1:0] SPUR = LINE_W'(LINES - 1);

   logic [LINE_W-1:0] eff_line;

   assign eff_line   = win_valid ? win_line : SPUR;
   assign poll_ack   = rd && poll_armed && win_valid;
   assign poll_line  = win_line;
   assign ack_vector = vec_base | DATA_W'(eff_line);

   always_comb begin
      if (poll_armed)  rdata = DATA_W'(eff_line);
      else if (addr)   rdata = DATA_W'(imr);
      else if (rsel)   rdata = DATA_W'(insvc);
      else             rdata = DATA_W'(pend);
   end
endmodule

// File: rtl/pic_regif.sv
module pic_regif
   import pic_regif_pkg::*;
#(
   parameter int LINES  = 8,
   parameter int DATA_W = 8,
   localparam int LINE_W = $clog2(LINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              addr,
   input  logic              wr,
   input  logic              rd,
   input  logic [DATA_W-1:0] wdata,
   input  logic [LINES-1:0]  pend,
   input  logic [LINES-1:0]  insvc,
   input  logic              win_valid,
   input  logic [LINE_W-1:0] win_line,
   output logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] vec_base,
   output logic              auto_eoi,
   output logic              sfn_mode,
   output logic              spec_mask,
   output logic [LINES-1:0]  imr,
   output logic              init_clr,
   output logic              cmd_valid,
   output logic [2:0]        cmd_code,
   output logic [LINE_W-1:0] cmd_level,
   output logic              poll_ack,
   output logic [LINE_W-1:0] poll_line,
   output logic [DATA_W-1:0] ack_vector
);
   generate
      if (LINES != 2 && LINES != 4 && LINES != 8) begin : g_bad_lines
         $error("pic_regif: LINES must be 2, 4 or 8");
      end
      if (DATA_W < 8) begin : g_bad_width
         $error("pic_regif: DATA_W must be at least 8");
      end
   endgenerate

   logic start_w, poll_armed, rsel;

   pic_ocw_dec #(.LINES(LINES), .DATA_W(DATA_W)) u_dec (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr(wr), .rd(rd),
      .wdata(wdata), .start_w(start_w), .cmd_valid(cmd_valid),
      .cmd_code(cmd_code), .cmd_level(cmd_level),
      .poll_armed(poll_armed), .rsel(rsel), .spec_mask(spec_mask)
   );

   pic_init_seq #(.LINES(LINES), .DATA_W(DATA_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .start_w(start_w), .wr_hi(wr && addr),
      .wdata(wdata), .vec_base(vec_base), .auto_eoi(auto_eoi),
      .sfn_mode(sfn_mode), .imr(imr)
   );

   pic_rd_path #(.LINES(LINES), .DATA_W(DATA_W)) u_rd (
      .addr(addr), .rd(rd), .poll_armed(poll_armed), .rsel(rsel),
      .pend(pend), .insvc(insvc), .imr(imr), .win_valid(win_valid),
      .win_line(win_line), .vec_base(vec_base), .rdata(rdata),
      .poll_ack(poll_ack), .poll_line(poll_line), .ack_vector(ack_vector)
   );

   assign init_clr = start_w;
endmodule

// File: tb/pic_regif_bench.sv
`timescale 1ns/100ps
module pic_regif_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       addr = 1'b0, wr = 1'b0, rd = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] pend = 8'hA5, insvc = 8'h3C;
   logic       win_valid = 1'b0;
   logic [2:0] win_line = '0;
   logic [7:0] rdata, vec_base, imr, ack_vector;
   logic       auto_eoi, sfn_mode, spec_mask, init_clr, cmd_valid, poll_ack;
   logic [2:0] cmd_code, cmd_level, poll_line;

   int n_chk = 0, n_bad = 0;
   logic       s_init, s_cmd, s_ack;
   logic [2:0] s_code, s_lvl, s_pline;
   logic [7:0] s_rdata;

   always #2.5 clk = ~clk;

   pic_regif u_pic_regif (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr(wr), .rd(rd), .wdata(wdata),
      .pend(pend), .insvc(insvc), .win_valid(win_valid), .win_line(win_line),
      .rdata(rdata), .vec_base(vec_base), .auto_eoi(auto_eoi),
      .sfn_mode(sfn_mode), .spec_mask(spec_mask), .imr(imr),
      .init_clr(init_clr), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
      .cmd_level(cmd_level), .poll_ack(poll_ack), .poll_line(poll_line),
      .ack_vector(ack_vector)
   );

   task automatic chk(input logic ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_wr(input logic a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr = 1'b1;
      #1;
      s_init = init_clr; s_cmd = cmd_valid; s_code = cmd_code; s_lvl = cmd_level;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic do_rd(input logic a);
      @(negedge clk);
      addr = a; rd = 1'b1;
      #1;
      s_rdata = rdata; s_ack = poll_ack; s_pline = poll_line;
      @(negedge clk);
      rd = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R11 reset state
      chk(imr == 0 && vec_base == 0, "R11 mask/base", {imr, vec_base}, 0);
      chk(!auto_eoi && !sfn_mode && !spec_mask, "R11 options", {auto_eoi, sfn_mode, spec_mask}, 0);
      chk(!init_clr && !cmd_valid && !poll_ack, "R11 strobes", {init_clr, cmd_valid, poll_ack}, 0);
      do_rd(1'b0);
      chk(s_rdata == pend, "R11 read pend", s_rdata, pend);

      // R5 and R9: mask load and readback, all values
      for (int v = 0; v < 256; v++) begin
         do_wr(1'b1, 8'(v));
         chk(imr == 8'(v), "R5 mask load", imr, v);
         do_rd(1'b1);
         chk(s_rdata == 8'(v), "R9 mask read", s_rdata, v);
      end

      // R1..R5: initialisation sequence, both flag values, every base
      for (int f = 0; f < 2; f++) begin
         for (int b = 0; b < 256; b++) begin
            do_wr(1'b1, 8'hFF);
            do_wr(1'b0, 8'h6B);                     // rsel=1, smask=1
            do_wr(1'b0, 8'h10 | 8'(f));
            chk(s_init == 1'b1, "R1 init pulse", s_init, 1);
            chk(imr == 0 && !spec_mask && !auto_eoi && !sfn_mode && vec_base == 0,
                "R1 cleared", {imr, spec_mask, auto_eoi, sfn_mode}, 0);
            do_wr(1'b1, 8'(b));
            chk(vec_base == (8'(b) & 8'hF8), "R2 base", vec_base, b & 8'hF8);
            chk(imr == 0, "R5 mask held in init", imr, 0);
            do_wr(1'b1, 8'hFF);
            chk(imr == 0 && vec_base == (8'(b) & 8'hF8) && !auto_eoi && !sfn_mode,
                "R3 third word ignored", imr, 0);
            if (f == 1) begin
               do_wr(1'b1, 8'(b));
               chk(sfn_mode == b[4] && auto_eoi == b[1], "R4 mode word",
                   {sfn_mode, auto_eoi}, {b[4], b[1]});
               chk(imr == 0, "R5 mask held in mode word", imr, 0);
            end
            do_wr(1'b1, 8'h5A);
            chk(imr == 8'h5A, "R3 back to normal", imr, 8'h5A);
            do_rd(1'b0);
            chk(s_rdata == pend, "R1 rsel cleared", s_rdata, pend);
         end
      end

      // R6, R8, R9: mode commands from every prior state
      for (int i = 0; i < 64; i++) begin
         for (int p = 0; p < 4; p++) begin
            logic [7:0] d;
            logic er, es, ep;
            do_rd(1'b0);
            do_wr(1'b0, 8'h4A | (8'(p >> 1) << 5) | 8'(p & 1));
            d  = {i[5], i[4], i[3], 1'b0, 1'b1, i[2], i[1], i[0]};
            er = d[1] ? d[0] : p[0];
            es = d[6] ? d[5] : p[1];
            ep = d[2];
            do_wr(1'b0, d);
            chk(!s_init && !s_cmd, "R6 no strobe", {s_init, s_cmd}, 0);
            chk(spec_mask == es, "R6 special mask", spec_mask, es);
            win_valid = 1'b1; win_line = 3'(i);
            do_rd(1'b0);
            if (ep) begin
               chk(s_rdata == 8'(i % 8) && s_ack && s_pline == 3'(i),
                   "R8 poll read", s_rdata, i % 8);
               do_rd(1'b0);
            end
            chk(s_rdata == (er ? insvc : pend) && !s_ack, "R9 read select",
                s_rdata, er ? insvc : pend);
            win_valid = 1'b0;
         end
      end

      // R7: all codes and levels
      do_wr(1'b1, 8'h33);
      for (int c = 0; c < 8; c++) begin
         for (int l = 0; l < 8; l++) begin
            do_wr(1'b0, 8'((c << 5) | l));
            chk(s_cmd && !s_init && s_code == 3'(c) && s_lvl == 3'(l), "R7 command",
                {s_cmd, s_code, s_lvl}, {1'b1, 3'(c), 3'(l)});
            chk(imr == 8'h33, "R7 mask untouched", imr, 8'h33);
         end
      end
      do_wr(1'b1, 8'h01);
      chk(!s_cmd, "R7 no strobe on address 1", s_cmd, 0);

      // R8: poll with no winner
      win_valid = 1'b0;
      do_wr(1'b0, 8'h0C);
      do_rd(1'b1);
      chk(s_rdata == 8'h07 && !s_ack, "R8 no winner", s_rdata, 7);
      do_rd(1'b1);
      chk(s_rdata == 8'h01, "R8 disarmed", s_rdata, 1);

      // R10: acknowledge vector
      do_wr(1'b0, 8'h10);
      do_wr(1'b1, 8'h4C);
      do_wr(1'b1, 8'h00);
      for (int l = 0; l < 8; l++) begin
         @(negedge clk);
         win_valid = 1'b1; win_line = 3'(l);
         #1;
         chk(ack_vector == (8'h48 | 8'(l)), "R10 vector", ack_vector, 8'h48 | l);
      end
      win_valid = 1'b0;
      #1;
      chk(ack_vector == 8'h4F, "R10 spurious vector", ack_vector, 8'h4F);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule